// File: doc/BRIEF.md
# Circular Transmit Buffer Sequencer

This block sends a transmit payload that can be far longer than the byte RAM window it reads from. A region of a 256-byte RAM is used as a ring. The ring starts at a programmable base address and its last location is base plus a programmable size. The sequencer reads each byte through a RAM read port with one cycle of latency. It hands the byte to a byte-serial output that uses a valid/ready handshake. After the last ring location it returns to the base address. This wrap is independent of how many bytes remain in the payload.

The host refills the ring in two halves, using two interrupt sources to know when to do so. The almost-full source is raised when the byte at base plus a threshold has been sent, which frees the lower part of the ring. The full source is raised when the byte at the end of the ring has been sent, which frees the upper part. Both sources are sticky, cleared by writing 1, and gated by a mask onto one interrupt line.

Transmission stops when either of these happens:
- A 16-bit total byte count has been sent. A one-cycle end-of-frame pulse marks this.
- An abort command is issued.

No framing bytes are inserted: every output byte comes from the ring. A configuration that would place the ring in the reserved low window or past the top of the RAM is flagged and cannot be started.

Top module: `ring_tx_seq`

## Requirements
- R1: After reset, busy_o, tx_valid_o, eof_o, irq_o and all bits of irq_src_o are 0.
- R2: cfg_err_o is 1 whenever base_i < 0x20 or base_i + size_i > 0xFF (9-bit sum), and then start_i leaves the block idle. RAM reads only ever address 0x20 or above.
- R3: After a start, the bytes sent are the RAM contents at base, base+1, ..., base+size, then base again, in that order. Each handshake (tx_valid_o and tx_ready_i high, abort_i low) carries exactly the byte at the current ring location, with nothing added.
- R4: After total_len_i handshakes, eof_o is high for exactly one cycle, the cycle after the final handshake, and busy_o falls in that same cycle. A start with total_len_i = 0 is ignored.
- R5: irq_src_o bit 5 (almost full) becomes 1 in the cycle after the handshake of the byte at base + thresh.
- R6: irq_src_o bit 6 (full) becomes 1 in the cycle after the handshake of the byte at base + size.
- R7: Source bits stay set until irq_clr_we_i is high with a 1 in that bit position. A set in the same cycle wins over the clear. Bits other than 5 and 6 always read 0.
- R8: irq_o equals the OR over all bits of irq_src_o AND irq_mask_i.
- R9: abort_i stops a running transfer. busy_o is 0 in the next cycle, a handshake in the abort cycle is not counted, and no eof_o pulse follows.
- R10: While tx_valid_o is high and tx_ready_i is low, tx_valid_o and tx_data_o stay unchanged in the next cycle (unless aborted).
- R11: base, size, threshold and total length are captured at start. Changing the inputs during a transfer does not alter the byte sequence or the interrupt points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_i | input | 8 | Ring start address |
| size_i | input | 8 | Offset of last ring location from base |
| thresh_i | input | 8 | Offset of the almost-full location from base |
| total_len_i | input | 16 | Payload length in bytes |
| start_i | input | 1 | Start command (accepted while idle) |
| abort_i | input | 1 | Abort command |
| irq_mask_i | input | 8 | Interrupt enables (bit 6 full, bit 5 almost full) |
| irq_clr_we_i | input | 1 | Write strobe for source clear |
| irq_clr_i | input | 8 | Write-1-to-clear bits for sources |
| ram_rd_o | output | 1 | RAM read strobe |
| ram_addr_o | output | 8 | RAM read address |
| ram_rdata_i | input | 8 | RAM read data, one cycle after strobe |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Output byte accepted |
| tx_data_o | output | 8 | Output byte |
| busy_o | output | 1 | Transfer in progress |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| cfg_err_o | output | 1 | Ring configuration outside allowed window |
| irq_src_o | output | 8 | Sticky interrupt sources |
| irq_o | output | 1 | Masked interrupt line |

## Verification
The hardest case to reach is the moment the host rewrites a ring half while the sequencer wraps into it. This requires the wrap, the interrupt points and the refill to interleave over many passes, with back-pressure shifting the timing.

The bench's reference model rewrites the freed half of its RAM at each almost-full and full event, using a new pattern on every pass. It runs a payload many times longer than the ring, with pseudo-random tx_ready_i, so any stale or early read shows up as a data mismatch.

Periodic clears during the run land in the same cycles as new sets. The degenerate one-byte ring, where both sources fire on every byte, is covered by a separate run.

// File: rtl/ring_tx_pkg.sv
package ring_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_SEND} tx_state_e;
  localparam int unsigned IRQ_W         = 8;
  localparam int unsigned IRQ_FULL_BIT  = 6;
  localparam int unsigned IRQ_AFULL_BIT = 5;
endpackage

// File: rtl/ring_tx_cfg_chk.sv
module ring_tx_cfg_chk #(
  parameter int unsigned AW        = 8,
  parameter int unsigned RESV_END  = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic          err_o
);
  localparam int unsigned MAX_ADDR = (1 << AW) - 1;

  logic [AW:0] end_w;
  assign end_w = {1'b0, base_i} + {1'b0, size_i};
  assign err_o = (base_i < AW'(RESV_END)) || (end_w > (AW+1)'(MAX_ADDR));
endmodule

// File: rtl/ring_tx_ptr.sv
module ring_tx_ptr #(
  parameter int unsigned AW = 8,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] thresh_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          at_thresh_o,
  output logic          at_end_o,
  output logic          last_o
);
  logic [AW-1:0] base_q, size_q, thr_q, ptr_q;
  logic [LW-1:0] len_q, cnt_q;
  logic [AW-1:0] end_addr;

  assign end_addr    = base_q + size_q;
  assign at_end_o    = (ptr_q == end_addr);
  // 9-bit compare: a threshold past the ring never matches
  assign at_thresh_o = ({1'b0, ptr_q} == ({1'b0, base_q} + {1'b0, thr_q}));
  assign last_o      = (({1'b0, cnt_q} + (LW+1)'(1)) == {1'b0, len_q});
  assign addr_o      = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      size_q <= '0;
      thr_q  <= '0;
      len_q  <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      size_q <= size_i;
      thr_q  <= thresh_i;
      len_q  <= len_i;
      ptr_q  <= base_i;
      cnt_q  <= '0;
    end else if (adv_i) begin
      ptr_q <= at_end_o ? base_q : ptr_q + AW'(1);
      cnt_q <= cnt_q + LW'(1);
    end
  end

  a_r3_ptr_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (ptr_q >= base_q) && (ptr_q <= end_addr));
  a_r3_wrap_to_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && at_end_o && !load_i) |=> (addr_o == $past(base_q)));
endmodule

// File: rtl/ring_tx_irq.sv
module ring_tx_irq import ring_tx_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_full_i,
  input  logic             set_afull_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] clr_i,
  input  logic [IRQ_W-1:0] mask_i,
  output logic [IRQ_W-1:0] src_o,
  output logic             irq_o
);
  wire [IRQ_W-1:0] src_w;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_src
    if (i == IRQ_FULL_BIT || i == IRQ_AFULL_BIT) begin : g_live
      logic set_w, bit_q;
      assign set_w = (i == IRQ_FULL_BIT) ? set_full_i : set_afull_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   bit_q <= 1'b0;
        else if (set_w)                bit_q <= 1'b1;
        else if (clr_we_i && clr_i[i]) bit_q <= 1'b0;
      end
      assign src_w[i] = bit_q;
    end else begin : g_tied
      assign src_w[i] = 1'b0;
    end
  end

  assign src_o = src_w;
  assign irq_o = |(src_w & mask_i);

  a_r7_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o[IRQ_FULL_BIT] && !(clr_we_i && clr_i[IRQ_FULL_BIT])) |=> src_o[IRQ_FULL_BIT]);
  a_r7_afull_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o[IRQ_AFULL_BIT] && !(clr_we_i && clr_i[IRQ_AFULL_BIT])) |=> src_o[IRQ_AFULL_BIT]);
  a_r6_full_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_full_i |=> src_o[IRQ_FULL_BIT]);
  a_r5_afull_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_afull_i |=> src_o[IRQ_AFULL_BIT]);
endmodule

// File: rtl/ring_tx_seq.sv
module ring_tx_seq import ring_tx_pkg::*; #(
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned LW       = 16,
  parameter int unsigned RESV_END = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    size_i,
  input  logic [AW-1:0]    thresh_i,
  input  logic [LW-1:0]    total_len_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [IRQ_W-1:0] irq_mask_i,
  input  logic             irq_clr_we_i,
  input  logic [IRQ_W-1:0] irq_clr_i,
  output logic             ram_rd_o,
  output logic [AW-1:0]    ram_addr_o,
  input  logic [DW-1:0]    ram_rdata_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [DW-1:0]    tx_data_o,
  output logic             busy_o,
  output logic             eof_o,
  output logic             cfg_err_o,
  output logic [IRQ_W-1:0] irq_src_o,
  output logic             irq_o
);
  tx_state_e     state_q, state_d;
  logic [DW-1:0] data_q;
  logic          eof_q;
  logic          load, fire, at_thresh, at_end, last;
  logic [AW-1:0] cur_addr;

  ring_tx_cfg_chk #(.AW(AW), .RESV_END(RESV_END)) u_cfg (
    .base_i (base_i),
    .size_i (size_i),
    .err_o  (cfg_err_o)
  );

  ring_tx_ptr #(.AW(AW), .LW(LW)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .adv_i       (fire),
    .base_i      (base_i),
    .size_i      (size_i),
    .thresh_i    (thresh_i),
    .len_i       (total_len_i),
    .addr_o      (cur_addr),
    .at_thresh_o (at_thresh),
    .at_end_o    (at_end),
    .last_o      (last)
  );

  ring_tx_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_full_i  (fire && at_end),
    .set_afull_i (fire && at_thresh),
    .clr_we_i    (irq_clr_we_i),
    .clr_i       (irq_clr_i),
    .mask_i      (irq_mask_i),
    .src_o       (irq_src_o),
    .irq_o       (irq_o)
  );

  assign load = (state_q == ST_IDLE) && start_i && !abort_i && !cfg_err_o
                && (total_len_i != '0);
  assign fire = (state_q == ST_SEND) && tx_ready_i && !abort_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_SEND;
      ST_SEND:  if (fire) state_d = last ? ST_IDLE : ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
    if (abort_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      eof_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      eof_q   <= fire && last;
      if (state_q == ST_LOAD) data_q <= ram_rdata_i;
    end
  end

  assign ram_rd_o   = (state_q == ST_FETCH);
  assign ram_addr_o = cur_addr;
  assign tx_valid_o = (state_q == ST_SEND);
  assign tx_data_o  = data_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign eof_o      = eof_q;

  a_r2_read_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o |-> (ram_addr_o >= AW'(RESV_END)));
  a_r2_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cfg_err_o) |=> !busy_o);
  a_r4_eof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
  a_r4_eof_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !busy_o);
  a_r9_abort_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !eof_o));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !abort_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: tb/ring_tx_seq_tb.sv
module ring_tx_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  base_i = 8'h40, size_i = 8'h0f, thresh_i = 8'h07;
  logic [15:0] total_len_i = 16'd0;
  logic        start_i = 0, abort_i = 0, irq_clr_we_i = 0, tx_ready_i = 1;
  logic [7:0]  irq_mask_i = 8'h00, irq_clr_i = 8'h00;
  logic        ram_rd_o, tx_valid_o, busy_o, eof_o, cfg_err_o, irq_o;
  logic [7:0]  ram_addr_o, tx_data_o, irq_src_o;
  logic [7:0]  ram_rdata = 8'h00;
  logic [7:0]  mem [256];

  always #4 clk = ~clk;

  ring_tx_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .base_i(base_i), .size_i(size_i),
    .thresh_i(thresh_i), .total_len_i(total_len_i), .start_i(start_i),
    .abort_i(abort_i), .irq_mask_i(irq_mask_i), .irq_clr_we_i(irq_clr_we_i),
    .irq_clr_i(irq_clr_i), .ram_rd_o(ram_rd_o), .ram_addr_o(ram_addr_o),
    .ram_rdata_i(ram_rdata), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .tx_data_o(tx_data_o), .busy_o(busy_o), .eof_o(eof_o), .cfg_err_o(cfg_err_o),
    .irq_src_o(irq_src_o), .irq_o(irq_o)
  );

  always @(posedge clk) if (ram_rd_o) ram_rdata <= mem[ram_addr_o];

  int vec = 0, bad = 0, nsent = 0, gen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  bit       m_busy = 0, m_eof = 0, p_hold = 0;
  bit [7:0] m_src = 0, p_data = 0, m_ptr = 0;
  int       m_base = 0, m_size = 0, m_thr = 0, m_len = 0, m_cnt = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      chk({busy_o, tx_valid_o, eof_o, irq_o, irq_src_o} == '0, "R1 reset outputs",
          {busy_o, tx_valid_o, eof_o, irq_o, irq_src_o}, 0);
      m_busy = 0; m_eof = 0; m_src = 0; p_hold = 0;
    end else begin
      bit err_exp, fire, n_busy, n_eof;
      bit [7:0] n_src;
      err_exp = (int'(base_i) < 32) || (int'(base_i) + int'(size_i) > 255);
      chk(cfg_err_o == err_exp, "R2 cfg_err", cfg_err_o, err_exp);
      chk(busy_o == m_busy, "R4 busy", busy_o, m_busy);
      chk(eof_o == m_eof, "R4 eof", eof_o, m_eof);
      chk(irq_src_o == m_src, "R7 irq_src", irq_src_o, m_src);
      chk(irq_o == |(m_src & irq_mask_i), "R8 irq", irq_o, |(m_src & irq_mask_i));
      if (!m_busy) chk(!tx_valid_o, "R9 valid while idle", tx_valid_o, 0);
      if (p_hold) chk(tx_valid_o && tx_data_o == p_data, "R10 hold",
                      {tx_valid_o, tx_data_o}, {1'b1, p_data});
      fire   = tx_valid_o && tx_ready_i && !abort_i;
      n_src  = m_src & ~(irq_clr_we_i ? irq_clr_i : 8'h00);
      n_busy = m_busy;
      n_eof  = 0;
      if (fire) begin
        int endp;
        endp = m_base + m_size;
        chk(tx_data_o == mem[m_ptr], "R3 data", tx_data_o, mem[m_ptr]);
        gen++;
        if (int'(m_ptr) == m_base + m_thr) begin
          n_src[5] = 1;
          for (int a = m_base; a <= m_base + m_thr && a <= endp; a++)
            mem[a] = 8'(a ^ (gen * 37));
        end
        if (int'(m_ptr) == endp) begin
          n_src[6] = 1;
          for (int a = m_base + m_thr + 1; a <= endp; a++)
            mem[a] = 8'(a ^ (gen * 53));
        end
        m_cnt++; nsent++;
        if (m_cnt == m_len) begin n_eof = 1; n_busy = 0; end
        m_ptr = (int'(m_ptr) == endp) ? 8'(m_base) : m_ptr + 8'd1;
      end
      if (abort_i) n_busy = 0;
      else if (!m_busy && start_i && !err_exp && total_len_i != 0) begin
        n_busy = 1; m_cnt = 0; nsent = 0;
        m_base = base_i; m_size = size_i; m_thr = thresh_i; m_len = total_len_i;
        m_ptr = base_i;
      end
      p_hold = tx_valid_o && !tx_ready_i && !abort_i;
      p_data = tx_data_o;
      m_src = n_src; m_eof = n_eof; m_busy = n_busy;
    end
  end

  // ready driver
  bit rnd_ready = 0;
  logic [15:0] lfsr = 16'hace1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready_i = rnd_ready ? lfsr[0] : 1'b1;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start(input int b, input int s, input int t, input int len);
    tick();
    base_i = 8'(b); size_i = 8'(s); thresh_i = 8'(t); total_len_i = 16'(len);
    start_i = 1;
    tick();
    start_i = 0;
  endtask

  task automatic run_wait(input bit do_clr);
    int cyc = 0;
    while (busy_o) begin
      irq_clr_we_i = do_clr && (cyc % 13 == 0);
      irq_clr_i    = 8'h60;
      cyc++;
      tick();
    end
    irq_clr_we_i = 0;
    tick();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'(a * 7 + 3);
    repeat (3) tick();
    rst_ni = 1;
    tick();

    // R2: bad configurations, boundary accepted
    do_start(8'h10, 8'h20, 8'h08, 10);
    chk(!busy_o, "R2 low base blocks start", busy_o, 0);
    do_start(8'hf0, 8'h20, 8'h08, 10);
    chk(!busy_o, "R2 overflow blocks start", busy_o, 0);
    // R4: zero length
    do_start(8'h40, 8'h0f, 8'h07, 0);
    chk(!busy_o, "R4 zero length ignored", busy_o, 0);

    // R3 R5 R6: short ring, full ready, mask both
    irq_mask_i = 8'h60;
    do_start(8'h40, 8'h0f, 8'h07, 40);
    chk(busy_o, "R3 start accepted", busy_o, 1);
    run_wait(0);
    chk(nsent == 40, "R4 byte count", nsent, 40);
    chk(irq_src_o == 8'h60, "R6 both sources set", irq_src_o, 8'h60);
    // R7: clear one bit at a time
    tick(); irq_clr_we_i = 1; irq_clr_i = 8'h20; tick(); irq_clr_we_i = 0;
    chk(irq_src_o == 8'h40, "R7 clear bit 5", irq_src_o, 8'h40);
    irq_clr_we_i = 1; irq_clr_i = 8'h40; tick(); irq_clr_we_i = 0;
    chk(irq_src_o == 8'h00, "R7 clear bit 6", irq_src_o, 0);

    // R2 boundary ring, random ready, periodic clears, refill traffic
    rnd_ready = 1; irq_mask_i = 8'h20;
    do_start(8'h20, 8'hdf, 8'h6f, 600);
    chk(busy_o, "R2 top boundary accepted", busy_o, 1);
    run_wait(1);
    chk(nsent == 600, "R4 long count", nsent, 600);

    // R9: abort mid-run
    irq_mask_i = 8'h00;
    do_start(8'h30, 8'h1f, 8'h0f, 1000);
    repeat (50) tick();
    abort_i = 1; tick(); abort_i = 0;
    chk(!busy_o, "R9 abort idles", busy_o, 0);
    chk(nsent < 1000, "R9 abort truncates", nsent, 999);

    // R11: config inputs change during run
    rnd_ready = 0; irq_mask_i = 8'h40;
    do_start(8'h80, 8'h07, 8'h03, 30);
    repeat (5) tick();
    base_i = 8'h30; size_i = 8'h05; thresh_i = 8'h01;
    run_wait(0);
    chk(nsent == 30, "R11 latched length", nsent, 30);

    // R5 R6: one-byte ring, both sources every byte
    rnd_ready = 1;
    do_start(8'h50, 8'h00, 8'h00, 5);
    run_wait(0);
    chk(irq_src_o == 8'h60, "R5 single-byte ring", irq_src_o, 8'h60);

    repeat (4) tick();
    done = 1;
    summary();
  end
endmodule